// File: doc/BRIEF.md
# Dual-Channel Compare-Match Interval Timer

This block is a small memory-mapped interval timer with two independent 16-bit channels. Each channel counts ticks of a prescaled copy of the system clock upward from its current value. When the count equals that channel's compare value, the next tick returns the counter to zero and sets a sticky match flag. A match flag can drive that channel's own interrupt output. Software uses it as a periodic tick source: it halts a channel, programs the period and prescale, and then sets the channel's run bit.

Access goes through a plain 16-bit register bus with single-cycle writes and registered reads. Register offsets are even. A run register at offset 0x0 holds one run bit per channel. Each channel then has three registers: control/status, counter and compare. Channel 0 has them at 0x2, 0x4 and 0x6, and channel 1 at 0x8, 0xA and 0xC.

Top module: `dual_match_timer`

## Requirements
- R1: After reset, the run register reads 0x0000. Every control/status register reads 0x0000, every counter reads 0x0000 and every compare register reads 0xFFFF. Both interrupt outputs are low.
- R2: A read with bus_sel=1 and bus_wr=0 returns the addressed register on bus_rdata one cycle later. The addresses are: run 0x0; channel 0 control 0x2, counter 0x4, compare 0x6; channel 1 control 0x8, counter 0xA, compare 0xC. Any other offset reads 0x0000, and so do all unused bits.
- R3: Bit n of the run register runs channel n. While a channel is halted, its counter holds its value and its prescaler is held at zero. The run register reads back exactly the value last written to its channel bits, so software can update one bit with a read-modify-write.
- R4: Control bits [1:0] hold the prescale code. The count tick period is 8 << (2*code) clock cycles: 8, 32, 128 or 512. After the run bit is written, the first tick arrives one full tick period later.
- R5: The counter advances by one on every tick. On a tick where the counter equals the compare value, the counter goes to 0 and control bit 7 (the match flag) sets on the same edge. Starting from counter 0 with compare C, the flag therefore sets (C+1) tick periods after the run-bit write.
- R6: Writing the control register with bit 7 = 0 clears the match flag, and writing it with bit 7 = 1 leaves the flag unchanged. If a match and a clearing write fall on the same edge, the match wins.
- R7: Control bit 6 enables the interrupt. irq_o[n] is high in the cycle after the cycle in which channel n has both its flag and its enable at 1, and is low in every other cycle.
- R8: Software can write the counter and the compare register at any time. A counter write takes priority over a tick on the same edge.
- R9: The channels are independent. Running, ticking, matching or writing one channel does not change the other channel's counter, flag or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq_o | output | 2 | One interrupt per channel |

## Verification
The checker watches these properties on every cycle:
- the interrupt equals the flag ANDed with the enable, delayed by one cycle;
- the flag rises only on a tick with counter equal to compare, and falls only on a control write with bit 7 = 0;
- the counter is zero right after a match;
- a halted counter holds its value.

Absolute timing needs the bench's scenarios. Those scenarios cover:
- the exact cycle count to a match for each prescale code;
- the prescaler restarting from zero after a halt;
- a preloaded counter shortening the first period;
- one channel staying idle while the other runs.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
  localparam int PRE_W         = 9;   // wide enough for the 512 divider
  localparam int CTRL_FLAG_BIT = 7;
  localparam int CTRL_IE_BIT   = 6;
  localparam int CH_STRIDE     = 6;   // bytes between channel register groups
  localparam int CH_FIRST      = 2;   // offset of channel 0 control register

  typedef enum int {
    KIND_CTRL  = 0,
    KIND_COUNT = 1,
    KIND_CMP   = 2
  } reg_kind_e;

  // byte offset of a channel register
  function automatic int reg_offset(int ch, reg_kind_e kind);
    return CH_FIRST + CH_STRIDE * ch + 2 * int'(kind);
  endfunction

  // last prescaler value before a tick for a 2-bit prescale code
  function automatic logic [PRE_W-1:0] pre_terminal(logic [1:0] code);
    int div;
    div = 8 << (2 * int'(code));
    return PRE_W'(div - 1);
  endfunction
endpackage

// File: rtl/dmt_prescaler.sv
module dmt_prescaler
  import dmt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] code,
  output logic       tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] term;

  always_comb begin
    term = pre_terminal(code);
    tick = run && (pre_q >= term);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) pre_q <= '0;
    else if (tick)   pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/dmt_channel.sv
module dmt_channel
  import dmt_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             ctrl_we,
  input  logic             cnt_we,
  input  logic             cmp_we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] ctrl_rd,
  output logic [REG_W-1:0] cnt_q,
  output logic [REG_W-1:0] cmp_q,
  output logic             flag_q,
  output logic             ie_q,
  output logic             tick,
  output logic             irq_q
);
  logic [1:0] code_q;
  logic       match;

  dmt_prescaler u_pre (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .code (code_q),
    .tick (tick)
  );

  assign match = tick && (cnt_q == cmp_q);

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (cnt_we) cnt_q <= wdata;
    else if (match)  cnt_q <= '0;
    else if (tick)   cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)         cmp_q <= '1;
    else if (cmp_we) cmp_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (ctrl_we) begin
        code_q <= wdata[1:0];
        ie_q   <= wdata[CTRL_IE_BIT];
      end
      if (match)                                flag_q <= 1'b1;
      else if (ctrl_we && !wdata[CTRL_FLAG_BIT]) flag_q <= 1'b0;
      irq_q <= flag_q && ie_q;
    end
  end

  always_comb begin
    ctrl_rd                = '0;
    ctrl_rd[1:0]           = code_q;
    ctrl_rd[CTRL_IE_BIT]   = ie_q;
    ctrl_rd[CTRL_FLAG_BIT] = flag_q;
  end
endmodule

// File: rtl/dual_match_timer.sv
module dual_match_timer
  import dmt_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int REG_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic [NUM_CH-1:0] irq_o
);
  localparam logic [ADDR_W-1:0] RUN_ADDR = '0;

  logic                          wr_en;
  logic [NUM_CH-1:0]             run_q;
  logic [NUM_CH-1:0]             ctrl_we, cnt_we, cmp_we;
  logic [NUM_CH-1:0]             flag_v, ie_v, tick_v, irq_v;
  logic [NUM_CH-1:0][REG_W-1:0]  ctrl_v, cnt_v, cmp_v;
  logic [REG_W-1:0]              rd_mux;

  assign wr_en = bus_sel && bus_wr;

  always_ff @(posedge clk) begin
    if (rst)                                 run_q <= '0;
    else if (wr_en && bus_addr == RUN_ADDR)  run_q <= bus_wdata[NUM_CH-1:0];
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(reg_offset(g, KIND_CTRL));
    localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(reg_offset(g, KIND_COUNT));
    localparam logic [ADDR_W-1:0] A_CMP  = ADDR_W'(reg_offset(g, KIND_CMP));

    assign ctrl_we[g] = wr_en && (bus_addr == A_CTRL);
    assign cnt_we[g]  = wr_en && (bus_addr == A_CNT);
    assign cmp_we[g]  = wr_en && (bus_addr == A_CMP);

    dmt_channel #(.REG_W(REG_W)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .run     (run_q[g]),
      .ctrl_we (ctrl_we[g]),
      .cnt_we  (cnt_we[g]),
      .cmp_we  (cmp_we[g]),
      .wdata   (bus_wdata),
      .ctrl_rd (ctrl_v[g]),
      .cnt_q   (cnt_v[g]),
      .cmp_q   (cmp_v[g]),
      .flag_q  (flag_v[g]),
      .ie_q    (ie_v[g]),
      .tick    (tick_v[g]),
      .irq_q   (irq_v[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == RUN_ADDR) rd_mux = REG_W'(run_q);
    for (int c = 0; c < NUM_CH; c++) begin
      if (bus_addr == ADDR_W'(reg_offset(c, KIND_CTRL)))  rd_mux = ctrl_v[c];
      if (bus_addr == ADDR_W'(reg_offset(c, KIND_COUNT))) rd_mux = cnt_v[c];
      if (bus_addr == ADDR_W'(reg_offset(c, KIND_CMP)))   rd_mux = cmp_v[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                     bus_rdata <= '0;
    else if (bus_sel && !bus_wr) bus_rdata <= rd_mux;
  end

  assign irq_o = irq_v;
endmodule

// File: rtl/dmt_checker.sv
module dmt_checker #(
  parameter int NUM_CH = 2,
  parameter int REG_W  = 16
) (
  input logic                         clk,
  input logic                         rst,
  input logic [NUM_CH-1:0]            run,
  input logic [NUM_CH-1:0]            tick,
  input logic [NUM_CH-1:0]            flag,
  input logic [NUM_CH-1:0]            ie,
  input logic [NUM_CH-1:0]            irq,
  input logic [NUM_CH-1:0]            ctrl_we,
  input logic [NUM_CH-1:0]            cnt_we,
  input logic                         wflag,
  input logic [NUM_CH-1:0][REG_W-1:0] cnt,
  input logic [NUM_CH-1:0][REG_W-1:0] cmp
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    assert_halt_holds_R3: assert property (@(posedge clk) disable iff (rst)
      (!run[i] && !cnt_we[i]) |=> $stable(cnt[i]));

    assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (rst)
      (tick[i] && cnt[i] == cmp[i] && !cnt_we[i]) |=> (cnt[i] == '0 && flag[i]));

    assert_flag_source_R5: assert property (@(posedge clk) disable iff (rst)
      $rose(flag[i]) |-> $past(tick[i] && cnt[i] == cmp[i]));

    assert_flag_clear_R6: assert property (@(posedge clk) disable iff (rst)
      $fell(flag[i]) |-> $past(ctrl_we[i] && !wflag));

    assert_irq_gate_R7: assert property (@(posedge clk) disable iff (rst)
      irq[i] == $past(flag[i] && ie[i]));
  end
endmodule

bind dual_match_timer dmt_checker #(.NUM_CH(NUM_CH), .REG_W(REG_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .run     (run_q),
  .tick    (tick_v),
  .flag    (flag_v),
  .ie      (ie_v),
  .irq     (irq_o),
  .ctrl_we (ctrl_we),
  .cnt_we  (cnt_we),
  .wflag   (bus_wdata[7]),
  .cnt     (cnt_v),
  .cmp     (cmp_v)
);

// File: tb/tb_dual_match_timer.sv
module tb_dual_match_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [1:0]  irq_o;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  dual_match_timer dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // {prescale code, compare value, cycles from run write to irq = (8<<2*code)*(C+1)+1}
  localparam int VEC [4][3] = '{
    '{0, 3, 33},
    '{1, 2, 97},
    '{2, 1, 257},
    '{3, 0, 513}
  };

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  // cycles from the run write edge until irq_o[ch] is seen high
  task automatic measure(input int ch, output int n);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (!irq_o[ch] && n < 4000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] d, d2;
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 / R2: reset values through the register map
    check("R1 irq", int'(irq_o), 0);
    rd(4'h0, d); check("R1 run", d, 16'h0000);
    rd(4'h2, d); check("R1 ctrl0", d, 16'h0000);
    rd(4'h4, d); check("R1 cnt0", d, 16'h0000);
    rd(4'h6, d); check("R1 cmp0", d, 16'hFFFF);
    rd(4'h8, d); check("R1 ctrl1", d, 16'h0000);
    rd(4'hA, d); check("R1 cnt1", d, 16'h0000);
    rd(4'hC, d); check("R1 cmp1", d, 16'hFFFF);
    rd(4'hE, d); check("R2 unused offset", d, 16'h0000);

    // R4 / R5: vector table, period per prescale code
    for (int v = 0; v < 4; v++) begin
      wr(4'h0, 16'h0000);
      wr(4'h4, 16'h0000);
      wr(4'h6, 16'(VEC[v][1]));
      wr(4'h2, 16'h0040 | 16'(VEC[v][0]));
      wr(4'h0, 16'h0001);
      measure(0, n);
      check("R4 R5 match period", n, VEC[v][2]);
      rd(4'h4, d); check("R5 count wraps to 0", d, 16'h0000);
      rd(4'h2, d); check("R5 flag set", d, 16'h00C0 | 16'(VEC[v][0]));
    end

    // R6: clear by writing 0, writing 1 has no effect
    wr(4'h0, 16'h0000);
    wr(4'h2, 16'h0043);
    rd(4'h2, d); check("R6 flag cleared", d, 16'h0043);
    check("R7 irq drops after clear", int'(irq_o[0]), 0);
    wr(4'h2, 16'h00C3);
    rd(4'h2, d); check("R6 write 1 no effect", d, 16'h0043);
    check("R6 irq stays low", int'(irq_o[0]), 0);

    // R7: interrupt gated by enable
    wr(4'h4, 16'h0000);
    wr(4'h6, 16'h0000);
    wr(4'h2, 16'h0000);
    wr(4'h0, 16'h0001);
    repeat (20) @(negedge clk);
    wr(4'h0, 16'h0000);
    rd(4'h2, d); check("R7 flag set with ie=0", d, 16'h0080);
    check("R7 irq low with ie=0", int'(irq_o[0]), 0);
    wr(4'h2, 16'h00C0);
    @(negedge clk);
    check("R7 irq high after enable", int'(irq_o[0]), 1);
    wr(4'h2, 16'h0040);
    @(negedge clk);
    check("R7 irq low after clear", int'(irq_o[0]), 0);

    // R3: halted counter holds
    wr(4'h4, 16'h0000);
    wr(4'h6, 16'd100);
    wr(4'h0, 16'h0001);
    repeat (45) @(negedge clk);
    wr(4'h0, 16'h0000);
    rd(4'h4, d);
    repeat (30) @(negedge clk);
    rd(4'h4, d2);
    check("R3 halted count holds", d2, d);
    check("R3 count advanced before halt", int'(d != 0), 1);

    // R8: preloaded counter shortens the first period (C-1 -> C -> match)
    wr(4'h4, 16'd4);
    wr(4'h6, 16'd5);
    wr(4'h2, 16'h0040);
    wr(4'h0, 16'h0001);
    measure(0, n);
    check("R8 preloaded count period", n, 17);

    // R9: independent channels
    wr(4'h0, 16'h0000);
    wr(4'h2, 16'h0040);
    wr(4'h4, 16'h0000);
    wr(4'h6, 16'd50);
    wr(4'hA, 16'h0000);
    wr(4'hC, 16'd1);
    wr(4'h8, 16'h0041);
    wr(4'h0, 16'h0002);
    measure(1, n);
    check("R9 ch1 period", n, 65);
    check("R9 ch0 irq idle", int'(irq_o[0]), 0);
    rd(4'h4, d); check("R9 ch0 count untouched", d, 16'h0000);
    rd(4'h0, d); check("R3 run readback", d, 16'h0002);
    wr(4'h0, d | 16'h0001);
    measure(0, n);
    check("R9 ch0 period with ch1 running", n, 409);
    rd(4'h0, d); check("R3 read-modify-write", d, 16'h0003);
    check("R9 ch1 irq still high", int'(irq_o[1]), 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule